// File: doc/BRIEF.md
# Packet Store-and-Forward Error Filter

This block sits in a receive stream after the logic that checks frames. That logic reports each packet's status on an error word that is only meaningful on the last beat. Because the verdict arrives only with the final beat, the filter writes every incoming packet into an on-chip buffer before it sends any of it on. When the last beat arrives, the filter either commits the packet or rolls its write pointer back to the last committed position. A committed packet gets a descriptor holding its length in beats. A rolled-back packet leaves no trace in the buffer. As a result, each packet either appears whole on the output or does not appear at all.

Both sides are valid/ready streams carrying data, start-of-packet, end-of-packet and error signals. The read side emits a packet only once its descriptor is queued. It rebuilds the start and end markers from the stored length and drives the error word to zero. A mask parameter selects which error bits count as fatal. A build-time switch can turn validation off, in which case every packet that fits in the buffer is forwarded. Two counters report how many packets were kept and how many were discarded.

Top module: `pkt_sf_filter`

## Requirements
- R1: After reset, `in_ready` is 1, `out_valid` is 0, and both `fwd_count` and `drop_count` are 0.
- R2: A kept packet leaves as the same number of beats it arrived with. `out_sop` is 1 only on its first beat, `out_eop` is 1 only on its last beat, and `out_err` is 0 on every beat.
- R3: With validation on, a packet is discarded whole if its `in_err` on the eop beat shares any set bit with `ERR_MASK`. No beat of it reaches the output, and `drop_count` rises by one.
- R4: No beat of a packet is presented on the output before the cycle after its eop beat is accepted on the input.
- R5: `in_err` on beats without eop has no effect on the verdict.
- R6: `in_err` bits that are clear in `ERR_MASK` never cause a discard. The error bit positions are: 0 PHY error, 1 CRC mismatch, 2 runt frame, 3 oversized frame, 4 length error, 5 receive overflow.
- R7: With `VALIDATE` = 0, every packet that fits in the buffer is forwarded, whatever its `in_err`.
- R8: A packet longer than the free buffer space is discarded whole, and `drop_count` rises by one. `in_ready` stays 1 for the rest of that packet. Packets that follow it are unaffected.
- R9: While `out_valid` is 1 and `out_ready` is 0, the output beat (`out_data`, `out_sop`, `out_eop`) holds steady.
- R10: `fwd_count` or `drop_count` rises by exactly one in the cycle after an eop beat is accepted. The two never rise together.
- R11: Kept packets leave in the order they arrived, with their beat data in order.
- R12: `in_ready` is 0 exactly when `DESC_DEPTH` committed packets are still waiting to finish leaving the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat accepted when high with in_valid |
| in_data | input | DATA_W | Input beat data |
| in_sop | input | 1 | First beat of an input packet |
| in_eop | input | 1 | Last beat of an input packet |
| in_err | input | ERR_W | Error status, meaningful on the eop beat only |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Downstream accepts the output beat |
| out_data | output | DATA_W | Output beat data |
| out_sop | output | 1 | First beat of an output packet |
| out_eop | output | 1 | Last beat of an output packet |
| out_err | output | ERR_W | Always zero on forwarded beats |
| fwd_count | output | CNT_W | Packets committed for forwarding |
| drop_count | output | CNT_W | Packets discarded |

## Verification
The assertions take the input framing as well formed: sop marks the first beat of each packet, eop marks the last, and every sop follows a completed packet. They also assume the counters do not wrap during a run. The stimulus sends whole packets only. It raises `in_valid` only in cycles where both filter instances under test are ready, so the two instances see an identical accepted stream. Counts stay far below the counter range. Backpressure comes from a shift-register pattern on `out_ready` or from holding it low, and it never touches the input framing.

// File: rtl/pkt_sf_pkg.sv
// Package for the store-and-forward filter.
// Holds the error-bit positions carried on the eop beat and the verdict
// type the write side hands to the rest of the block.
package pkt_sf_pkg;
    localparam int ERRB_PHY   = 0;
    localparam int ERRB_CRC   = 1;
    localparam int ERRB_RUNT  = 2;
    localparam int ERRB_GIANT = 3;
    localparam int ERRB_LEN   = 4;
    localparam int ERRB_OVF   = 5;

    typedef enum logic [1:0] {
        VERD_NONE = 2'd0,
        VERD_KEEP = 2'd1,
        VERD_DROP = 2'd2
    } verdict_t;
endpackage

// File: rtl/pkt_sf_buffer.sv
// Packet payload storage: one synchronous write port and one
// asynchronous read port.
// Assumes the write address never equals a read address that holds
// committed data (guaranteed by the writer's space check).
module pkt_sf_buffer #(
    parameter int W     = 8,
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] mem_q [DEPTH];

    // store one accepted beat
    always_ff @(posedge clk) begin
        if (we) mem_q[waddr] <= wdata;
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/pkt_sf_desc_fifo.sv
// Queue of committed packet lengths, from the write side to the read side.
// Assumes DEPTH is a power of two and at least 2, and that push never
// happens while full (the top holds off input when full).
module pkt_sf_desc_fifo #(
    parameter int W     = 5,
    parameter int DEPTH = 4,
    localparam int AW   = $clog2(DEPTH),
    localparam int PW   = AW + 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_len,
    input  logic         pop,
    output logic [W-1:0] head_len,
    output logic         empty,
    output logic         full
);
    logic [W-1:0]  slot_q [DEPTH];
    logic [PW-1:0] wp_q, rp_q;

    // write a new descriptor into its slot
    always_ff @(posedge clk) begin
        if (push) slot_q[wp_q[AW-1:0]] <= push_len;
    end

    // advance the queue pointers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp_q <= '0;
            rp_q <= '0;
        end else begin
            if (push) wp_q <= wp_q + 1'b1;
            if (pop)  rp_q <= rp_q + 1'b1;
        end
    end

    assign head_len = slot_q[rp_q[AW-1:0]];
    assign empty    = (wp_q == rp_q);
    assign full     = (wp_q[AW-1:0] == rp_q[AW-1:0]) && (wp_q[AW] != rp_q[AW]);
endmodule

// File: rtl/pkt_sf_writer.sv
// Write side of the filter. Keeps a speculative and a committed write
// pointer. At eop it either commits the packet (verdict KEEP, with the
// length) or rewinds to the committed pointer (verdict DROP). A beat that
// finds the buffer full dooms the rest of its packet.
// Assumes well-formed framing; a sop restarts from the committed pointer.
module pkt_sf_writer
    import pkt_sf_pkg::*;
#(
    parameter int DEPTH              = 16,
    parameter int ERR_W              = 6,
    parameter logic [ERR_W-1:0] ERR_MASK = '1,
    parameter bit VALIDATE           = 1'b1,
    localparam int AW                = $clog2(DEPTH),
    localparam int PW                = AW + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             accept,
    input  logic             in_sop,
    input  logic             in_eop,
    input  logic [ERR_W-1:0] in_err,
    input  logic [PW-1:0]    rd_ptr,
    output logic             mem_we,
    output logic [AW-1:0]    mem_waddr,
    output logic [PW-1:0]    pkt_len,
    output verdict_t         verdict
);
    logic [PW-1:0] spec_q, commit_q, len_q;
    logic          doom_q;
    logic [PW-1:0] base_ptr, base_len, fill;
    logic          base_doom, full, err_hit, bad;

    // pick the error judgement variant at build time
    generate
        if (VALIDATE) begin : g_judge
            assign err_hit = |(in_err & ERR_MASK);
        end else begin : g_pass
            assign err_hit = 1'b0;
        end
    endgenerate

    // current packet position, space check and verdict
    always_comb begin
        base_ptr  = in_sop ? commit_q : spec_q;
        base_len  = in_sop ? '0 : len_q;
        base_doom = in_sop ? 1'b0 : doom_q;
        fill      = base_ptr - rd_ptr;
        full      = (fill == PW'(DEPTH));
        mem_we    = accept && !base_doom && !full;
        bad       = base_doom || full || err_hit;
        pkt_len   = base_len + 1'b1;
        if (accept && in_eop) verdict = bad ? VERD_DROP : VERD_KEEP;
        else                  verdict = VERD_NONE;
    end

    assign mem_waddr = base_ptr[AW-1:0];

    // move, commit or rewind the write pointers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            spec_q   <= '0;
            commit_q <= '0;
            len_q    <= '0;
            doom_q   <= 1'b0;
        end else if (accept) begin
            if (in_eop) begin
                if (bad) begin
                    spec_q <= commit_q;
                end else begin
                    spec_q   <= base_ptr + 1'b1;
                    commit_q <= base_ptr + 1'b1;
                end
                len_q  <= '0;
                doom_q <= 1'b0;
            end else begin
                spec_q <= mem_we ? base_ptr + 1'b1 : base_ptr;
                len_q  <= mem_we ? base_len + 1'b1 : base_len;
                doom_q <= base_doom || full;
            end
        end
    end
endmodule

// File: rtl/pkt_sf_reader.sv
// Read side of the filter. Emits the packet at the head of the descriptor
// queue beat by beat, rebuilding sop and eop from the stored length.
// Assumes every queued length is at least 1.
module pkt_sf_reader #(
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH),
    localparam int PW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          desc_empty,
    input  logic [PW-1:0] desc_len,
    input  logic          out_ready,
    output logic          desc_pop,
    output logic          out_valid,
    output logic          out_sop,
    output logic          out_eop,
    output logic [PW-1:0] rd_ptr
);
    logic [PW-1:0] beat_q;
    logic          fire;

    // framing of the current output beat
    always_comb begin
        out_valid = !desc_empty;
        out_sop   = (beat_q == '0);
        out_eop   = (beat_q == desc_len - 1'b1);
        fire      = out_valid && out_ready;
        desc_pop  = fire && out_eop;
    end

    // step the read pointer and beat index on each delivered beat
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            beat_q <= '0;
        end else if (fire) begin
            rd_ptr <= rd_ptr + 1'b1;
            beat_q <= out_eop ? '0 : beat_q + 1'b1;
        end
    end
endmodule

// File: rtl/pkt_sf_filter.sv
// Top of the store-and-forward error filter. Buffers each packet whole,
// judges it on the error word of its eop beat, and forwards kept packets
// with clean framing. Counts kept and discarded packets.
// Assumes BUF_DEPTH and DESC_DEPTH are powers of two and at least 2.
module pkt_sf_filter
    import pkt_sf_pkg::*;
#(
    parameter int DATA_W             = 32,
    parameter int ERR_W              = 6,
    parameter int BUF_DEPTH          = 256,
    parameter int DESC_DEPTH         = 16,
    parameter int CNT_W              = 16,
    parameter logic [ERR_W-1:0] ERR_MASK = '1,
    parameter bit VALIDATE           = 1'b1,
    localparam int AW                = $clog2(BUF_DEPTH),
    localparam int PW                = AW + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_sop,
    input  logic              in_eop,
    input  logic [ERR_W-1:0]  in_err,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_data,
    output logic              out_sop,
    output logic              out_eop,
    output logic [ERR_W-1:0]  out_err,
    output logic [CNT_W-1:0]  fwd_count,
    output logic [CNT_W-1:0]  drop_count
);
    logic          accept, mem_we, desc_full, desc_empty, desc_pop;
    logic [AW-1:0] mem_waddr;
    logic [PW-1:0] pkt_len, head_len, rd_ptr;
    verdict_t      verdict;

    assign in_ready = !desc_full;
    assign accept   = in_valid && in_ready;
    assign out_err  = '0;

    pkt_sf_writer #(
        .DEPTH(BUF_DEPTH), .ERR_W(ERR_W), .ERR_MASK(ERR_MASK), .VALIDATE(VALIDATE)
    ) writer_i (
        .clk(clk), .rst_n(rst_n), .accept(accept), .in_sop(in_sop),
        .in_eop(in_eop), .in_err(in_err), .rd_ptr(rd_ptr), .mem_we(mem_we),
        .mem_waddr(mem_waddr), .pkt_len(pkt_len), .verdict(verdict)
    );

    pkt_sf_buffer #(.W(DATA_W), .DEPTH(BUF_DEPTH)) buffer_i (
        .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(in_data),
        .raddr(rd_ptr[AW-1:0]), .rdata(out_data)
    );

    pkt_sf_desc_fifo #(.W(PW), .DEPTH(DESC_DEPTH)) desc_i (
        .clk(clk), .rst_n(rst_n), .push(verdict == VERD_KEEP),
        .push_len(pkt_len), .pop(desc_pop), .head_len(head_len),
        .empty(desc_empty), .full(desc_full)
    );

    pkt_sf_reader #(.DEPTH(BUF_DEPTH)) reader_i (
        .clk(clk), .rst_n(rst_n), .desc_empty(desc_empty), .desc_len(head_len),
        .out_ready(out_ready), .desc_pop(desc_pop), .out_valid(out_valid),
        .out_sop(out_sop), .out_eop(out_eop), .rd_ptr(rd_ptr)
    );

    // count kept and discarded packets
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fwd_count  <= '0;
            drop_count <= '0;
        end else begin
            if (verdict == VERD_KEEP) fwd_count  <= fwd_count + 1'b1;
            if (verdict == VERD_DROP) drop_count <= drop_count + 1'b1;
        end
    end
endmodule

// File: rtl/pkt_sf_filter_chk.sv
// Checker for the store-and-forward filter, attached to every instance
// of the top by the bind below. Tracks output packet boundaries and the
// number of packets fully delivered.
// Assumes well-formed input framing and no counter wrap.
module pkt_sf_filter_chk #(
    parameter int DATA_W             = 32,
    parameter int ERR_W              = 6,
    parameter int DESC_DEPTH         = 16,
    parameter int CNT_W              = 16,
    parameter logic [ERR_W-1:0] ERR_MASK = '1,
    parameter bit VALIDATE           = 1'b1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_ready,
    input logic              in_eop,
    input logic [ERR_W-1:0]  in_err,
    input logic              out_valid,
    input logic              out_ready,
    input logic [DATA_W-1:0] out_data,
    input logic              out_sop,
    input logic              out_eop,
    input logic [CNT_W-1:0]  fwd_count,
    input logic [CNT_W-1:0]  drop_count
);
    logic             open_q;
    logic [CNT_W-1:0] done_q;

    // follow the output packet boundary and count delivered packets
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            open_q <= 1'b0;
            done_q <= '0;
        end else if (out_valid && out_ready) begin
            open_q <= !out_eop;
            if (out_eop) done_q <= done_q + 1'b1;
        end
    end

    // R2
    first_beat_sop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_sop == !open_q));

    // R9
    hold_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=>
        (out_valid && $stable(out_data) && $stable(out_sop) && $stable(out_eop)));

    // R3
    masked_err_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_eop && VALIDATE && ((in_err & ERR_MASK) != '0))
        |=> (drop_count == $past(drop_count) + 1'b1));

    // R10
    single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ($countones({fwd_count != $past(fwd_count),
                              drop_count != $past(drop_count)}) <= 1));

    // R4
    no_early_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && out_eop) |-> (done_q < fwd_count));

    // R12
    ready_space_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready == ((fwd_count - done_q) < CNT_W'(DESC_DEPTH)));
endmodule

bind pkt_sf_filter pkt_sf_filter_chk #(
    .DATA_W(DATA_W), .ERR_W(ERR_W), .DESC_DEPTH(DESC_DEPTH), .CNT_W(CNT_W),
    .ERR_MASK(ERR_MASK), .VALIDATE(VALIDATE)
) chk_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_eop(in_eop), .in_err(in_err), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .out_sop(out_sop),
    .out_eop(out_eop), .fwd_count(fwd_count), .drop_count(drop_count)
);

// File: tb/pkt_sf_filter_tb_top.sv
// Behavioural reference: queues of stored beats and packet lengths,
// updated once per rising edge from the same inputs the design sees.
module pkt_sf_ref #(
    parameter int DEPTH      = 16,
    parameter int DESC_DEPTH = 4,
    parameter logic [5:0] MASK = 6'h3F,
    parameter bit VALIDATE   = 1'b1
) (
    input logic       clk,
    input logic       rst_n,
    input logic       in_valid,
    input logic [7:0] in_data,
    input logic       in_eop,
    input logic [5:0] in_err,
    input logic       out_ready
);
    logic [7:0] outq[$];
    int         lenq[$];
    logic [7:0] cur[$];
    bit         doom;
    int         obeat, fwds, drops;
    bit         exp_ready, exp_valid, exp_sop, exp_eop;
    logic [7:0] exp_data;

    // advance the model one clock
    always @(posedge clk) begin
        bit fire, rdy, full, bad;
        if (!rst_n) begin
            outq.delete(); lenq.delete(); cur.delete();
            doom = 0; obeat = 0; fwds = 0; drops = 0;
        end else begin
            fire = (lenq.size() > 0) && out_ready;
            rdy  = lenq.size() < DESC_DEPTH;
            full = (outq.size() + cur.size()) == DEPTH;
            if (fire) begin
                void'(outq.pop_front());
                if (obeat == lenq[0] - 1) begin
                    void'(lenq.pop_front());
                    obeat = 0;
                end else obeat++;
            end
            if (in_valid && rdy) begin
                if (!doom && !full) cur.push_back(in_data);
                if (in_eop) begin
                    bad = doom || full || (VALIDATE && ((in_err & MASK) != 0));
                    if (bad) drops++;
                    else begin
                        foreach (cur[i]) outq.push_back(cur[i]);
                        lenq.push_back(cur.size());
                        fwds++;
                    end
                    cur.delete();
                    doom = 0;
                end else if (full) doom = 1;
            end
        end
        exp_ready = lenq.size() < DESC_DEPTH;
        exp_valid = lenq.size() > 0;
        exp_sop   = (obeat == 0);
        exp_eop   = exp_valid && (obeat == lenq[0] - 1);
        exp_data  = exp_valid ? outq[0] : 8'h00;
    end
endmodule

// Bench: two filters (validation on with a partial mask, validation off)
// driven by one accepted stream, each compared with its own model.
module pkt_sf_filter_tb_top;
    import pkt_sf_pkg::*;

    localparam int DEPTH = 16;
    localparam int DDEP  = 4;
    localparam logic [5:0] MASK_A = 6'h3F & ~(6'd1 << ERRB_GIANT);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0;
    logic [7:0] in_data = '0;
    logic [5:0] in_err = '0;
    logic bp_mode = 1'b0, rdy_manual = 1'b1;
    logic [7:0] lfsr = 8'h5A;
    logic out_ready;
    bit   cmp_on = 0, done = 0;
    int   vectors = 0, fails = 0;

    logic a_ready, a_valid, a_sop, a_eop, n_ready, n_valid, n_sop, n_eop;
    logic [7:0] a_data, n_data;
    logic [5:0] a_err, n_err;
    logic [15:0] a_fwd, a_drop, n_fwd, n_drop;

    always #5 clk = ~clk;

    assign out_ready = bp_mode ? lfsr[0] : rdy_manual;

    // backpressure pattern
    always @(negedge clk) lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};

    pkt_sf_filter #(.DATA_W(8), .ERR_W(6), .BUF_DEPTH(DEPTH), .DESC_DEPTH(DDEP),
        .CNT_W(16), .ERR_MASK(MASK_A), .VALIDATE(1'b1)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(a_ready),
        .in_data(in_data), .in_sop(in_sop), .in_eop(in_eop), .in_err(in_err),
        .out_valid(a_valid), .out_ready(out_ready), .out_data(a_data),
        .out_sop(a_sop), .out_eop(a_eop), .out_err(a_err),
        .fwd_count(a_fwd), .drop_count(a_drop));

    pkt_sf_filter #(.DATA_W(8), .ERR_W(6), .BUF_DEPTH(DEPTH), .DESC_DEPTH(DDEP),
        .CNT_W(16), .ERR_MASK(6'h3F), .VALIDATE(1'b0)) dut_nv_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(n_ready),
        .in_data(in_data), .in_sop(in_sop), .in_eop(in_eop), .in_err(in_err),
        .out_valid(n_valid), .out_ready(out_ready), .out_data(n_data),
        .out_sop(n_sop), .out_eop(n_eop), .out_err(n_err),
        .fwd_count(n_fwd), .drop_count(n_drop));

    pkt_sf_ref #(.DEPTH(DEPTH), .DESC_DEPTH(DDEP), .MASK(MASK_A), .VALIDATE(1'b1)) ref_a (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_eop(in_eop), .in_err(in_err), .out_ready(out_ready));

    pkt_sf_ref #(.DEPTH(DEPTH), .DESC_DEPTH(DDEP), .MASK(6'h3F), .VALIDATE(1'b0)) ref_n (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_eop(in_eop), .in_err(in_err), .out_ready(out_ready));

    task automatic check(input bit ok, input string what, input int act, input int exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%0d exp=%0d at %0t", what, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    endtask

    // per-cycle comparison of both instances with their models
    always @(negedge clk) begin
        if (cmp_on) begin
            check(a_ready == ref_a.exp_ready, "R12 A in_ready", a_ready, ref_a.exp_ready);
            check(a_valid == ref_a.exp_valid, "R4 A out_valid", a_valid, ref_a.exp_valid);
            if (ref_a.exp_valid) begin
                check(a_sop == ref_a.exp_sop, "R2 A out_sop", a_sop, ref_a.exp_sop);
                check(a_eop == ref_a.exp_eop, "R2 A out_eop", a_eop, ref_a.exp_eop);
                check(a_data == ref_a.exp_data, "R9 R11 A out_data", a_data, ref_a.exp_data);
                check(a_err == 6'd0, "R2 A out_err", a_err, 0);
            end
            check(int'(a_fwd) == ref_a.fwds, "R10 A fwd_count", a_fwd, ref_a.fwds);
            check(int'(a_drop) == ref_a.drops, "R10 A drop_count", a_drop, ref_a.drops);
            check(n_ready == ref_n.exp_ready, "R12 N in_ready", n_ready, ref_n.exp_ready);
            check(n_valid == ref_n.exp_valid, "R7 N out_valid", n_valid, ref_n.exp_valid);
            if (ref_n.exp_valid) begin
                check(n_sop == ref_n.exp_sop, "R7 N out_sop", n_sop, ref_n.exp_sop);
                check(n_eop == ref_n.exp_eop, "R7 N out_eop", n_eop, ref_n.exp_eop);
                check(n_data == ref_n.exp_data, "R7 N out_data", n_data, ref_n.exp_data);
            end
            check(int'(n_fwd) == ref_n.fwds, "R7 N fwd_count", n_fwd, ref_n.fwds);
            check(int'(n_drop) == ref_n.drops, "R7 N drop_count", n_drop, ref_n.drops);
        end
    end

    // send one packet; beats go out only when both instances are ready
    task automatic send_pkt(input int len, input int seed, input logic [5:0] eop_err,
                            input logic [5:0] mid_err, output int stalls);
        stalls = 0;
        for (int b = 0; b < len; b++) begin
            @(negedge clk);
            while (!(a_ready && n_ready)) begin
                in_valid = 1'b0;
                stalls++;
                @(negedge clk);
            end
            in_valid = 1'b1;
            in_data  = 8'(seed + b * 7);
            in_sop   = (b == 0);
            in_eop   = (b == len - 1);
            in_err   = (b == len - 1) ? eop_err : mid_err;
        end
        @(negedge clk);
        in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0; in_err = '0;
    endtask

    task automatic drain();
        bp_mode = 1'b0;
        rdy_manual = 1'b1;
        repeat (60) @(negedge clk);
    endtask

    task automatic expect_counts(input string tag, input int af, input int ad,
                                 input int nf, input int nd);
        check(int'(a_fwd) == af, {tag, " A fwd"}, a_fwd, af);
        check(int'(a_drop) == ad, {tag, " A drop"}, a_drop, ad);
        check(int'(n_fwd) == nf, {tag, " N fwd"}, n_fwd, nf);
        check(int'(n_drop) == nd, {tag, " N drop"}, n_drop, nd);
    endtask

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog R11 act=0 exp=1");
        finish_run();
    end

    initial begin
        int st;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        check(a_ready == 1'b1, "R1 in_ready", a_ready, 1);
        check(a_valid == 1'b0, "R1 out_valid", a_valid, 0);
        check(a_fwd == 16'd0 && a_drop == 16'd0, "R1 counts", a_fwd + a_drop, 0);
        rst_n = 1'b1;
        @(negedge clk);
        cmp_on = 1;

        // R2 R4: clean packet
        send_pkt(5, 8'h10, 6'd0, 6'd0, st);
        drain();
        expect_counts("R2", 1, 0, 1, 0);
        // R3: CRC error at eop
        send_pkt(4, 8'h20, 6'(1 << ERRB_CRC), 6'd0, st);
        drain();
        expect_counts("R3", 1, 1, 2, 0);
        // R5: errors on middle beats only
        send_pkt(6, 8'h30, 6'd0, 6'h3F, st);
        drain();
        expect_counts("R5", 2, 1, 3, 0);
        // R6: masked-out oversize bit kept, overflow bit dropped
        send_pkt(3, 8'h40, 6'(1 << ERRB_GIANT), 6'd0, st);
        drain();
        expect_counts("R6", 3, 1, 4, 0);
        send_pkt(3, 8'h48, 6'(1 << ERRB_OVF), 6'd0, st);
        drain();
        expect_counts("R6 R7", 3, 2, 5, 0);
        // single-beat packets
        send_pkt(1, 8'h50, 6'd0, 6'd0, st);
        send_pkt(1, 8'h58, 6'(1 << ERRB_PHY), 6'd0, st);
        drain();
        expect_counts("R2 R3", 4, 3, 7, 0);
        // R9 R11: back-to-back under random backpressure, one bad packet
        bp_mode = 1'b1;
        send_pkt(2, 8'h60, 6'd0, 6'd0, st);
        send_pkt(3, 8'h68, 6'd0, 6'd0, st);
        send_pkt(4, 8'h70, 6'd0, 6'd0, st);
        send_pkt(3, 8'h78, 6'(1 << ERRB_LEN), 6'd0, st);
        send_pkt(2, 8'h80, 6'd0, 6'd0, st);
        send_pkt(1, 8'h88, 6'd0, 6'd0, st);
        drain();
        expect_counts("R9 R11", 9, 4, 13, 0);
        // R8: packet larger than the buffer, output stalled
        rdy_manual = 1'b0;
        send_pkt(20, 8'h90, 6'd0, 6'd0, st);
        check(st == 0, "R8 in_ready stalls", st, 0);
        drain();
        expect_counts("R8", 9, 5, 13, 1);
        send_pkt(6, 8'hA0, 6'd0, 6'd0, st);
        drain();
        expect_counts("R8 after", 10, 5, 14, 1);
        // R12: descriptor queue fills
        rdy_manual = 1'b0;
        for (int p = 0; p < DDEP; p++) send_pkt(2, 8'hB0 + p * 16, 6'd0, 6'd0, st);
        check(a_ready == 1'b0, "R12 full in_ready", a_ready, 0);
        fork
            send_pkt(2, 8'hF0, 6'd0, 6'd0, st);
            begin
                repeat (20) @(negedge clk);
                rdy_manual = 1'b1;
            end
        join
        check(st > 0, "R12 stall seen", st, 1);
        drain();
        expect_counts("R12", 15, 5, 19, 1);
        finish_run();
    end
endmodule